// File: doc/BRIEF.md
# Root Port Interrupt Front End

This block collects the interrupt sources of a PCIe root port bridge behind a small 32-bit register port. Single-cycle event pulses are latched into a sticky pending register. Software clears that register by writing ones. A mask register selects which pending bits drive the one interrupt line.

Legacy line interrupts and message-signalled interrupts arrive as push strobes. They are queued in an interrupt queue. Error messages and the requester ID of each one are queued in a separate error queue. Software reads the head entry of a queue through fixed registers and removes it by writing any value to the queue's first register. Each queue raises a sticky overflow flag when an entry arrives while the queue is full.

Top module: `rp_irq_frontend`

## Requirements
- R1: After reset, the pending, mask and queue registers all read 0. `irq_out`, `intq_ovf` and `errq_ovf` are low.
- R2: A high bit of `event_in` sets the pending bit at the same position (offset 0x138) at the next clock edge. Only the bits of 0x1FF30FED can be set. All other pending bits always read 0.
- R3: Writing to offset 0x138 clears each pending bit that has a 1 in the write data. If a bit is set and cleared in the same cycle, setting wins.
- R4: The mask at offset 0x13C is read/write, but only the bits of 0x1FF30FED are stored. `irq_out` is high exactly when some bit is high in both the pending and mask registers, one edge after either register changes.
- R5: An accepted interrupt-queue push sets pending bit 16 for a line interrupt (`intq_msi`=0) or bit 17 for a message (`intq_msi`=1). The head word at 0x158 has valid in bit 31, the message flag in bit 30 and the line number (0..3) in bits 28:27, with all other bits 0.
- R6: Offset 0x15C returns the 16-bit message data of the interrupt-queue head in bits 15:0, with all upper bits 0.
- R7: An accepted error-queue push sets pending bit 9, 10 or 11 for `errq_sev` 0, 1 or 2; the value 3 also sets bit 11. The head word at 0x154 has valid in bit 18 and the requester ID in bits 15:0, with all other bits 0.
- R8: Any write to 0x158 pops the interrupt queue. Any write to 0x154 pops the error queue. A pop of an empty queue has no effect.
- R9: Each queue holds DEPTH (default 8) entries and returns them in arrival order.
- R10: A push into a full queue with no pop in the same cycle is dropped. It leaves the pending register unchanged and sets that queue's overflow flag, which stays high until reset.
- R11: While a queue is empty, all of its read registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| event_in | input | 32 | Event pulses, one per pending bit |
| intq_push | input | 1 | Push an interrupt-queue entry |
| intq_msi | input | 1 | 1: message entry, 0: line interrupt entry |
| intq_line | input | 2 | Line number 0..3 |
| intq_data | input | 16 | Message data |
| errq_push | input | 1 | Push an error-queue entry |
| errq_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal |
| errq_reqid | input | 16 | Requester ID |
| irq_out | output | 1 | Interrupt request |
| intq_ovf | output | 1 | Sticky interrupt-queue overflow |
| errq_ovf | output | 1 | Sticky error-queue overflow |

## Verification
Each push, event and register write takes effect at the first rising edge after it is driven. The pending register, the queue heads, the overflow flags and `irq_out` are therefore due one edge later. Read data is combinational from the address, so a read result is due as soon as the address settles.

The bench drives every stimulus on a falling edge and keeps it for exactly one cycle. It reads and compares on a later falling edge, one nanosecond after setting the address. Every expected value thus falls after the one edge that should have produced it and well before the next.

// File: rtl/rp_irq_frontend.sv
module rp_irq_frontend #(
  parameter int          ADDR_W = 12,
  parameter int          DEPTH  = 8,
  parameter logic [31:0] IMPL   = 32'h1FF3_0FED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       event_in,
  input  logic              intq_push,
  input  logic              intq_msi,
  input  logic [1:0]        intq_line,
  input  logic [15:0]       intq_data,
  input  logic              errq_push,
  input  logic [1:0]        errq_sev,
  input  logic [15:0]       errq_reqid,
  output logic              irq_out,
  output logic              intq_ovf,
  output logic              errq_ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_DEC = ADDR_W'('h138);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'('h13C);
  localparam logic [ADDR_W-1:0] A_EQ  = ADDR_W'('h154);
  localparam logic [ADDR_W-1:0] A_IQ1 = ADDR_W'('h158);
  localparam logic [ADDR_W-1:0] A_IQ2 = ADDR_W'('h15C);
  localparam logic [CW-1:0]     FULL  = CW'(DEPTH);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [31:0] decode, mask, set_v, clr_v;
  logic [18:0] iq_mem [DEPTH];
  logic [15:0] eq_mem [DEPTH];
  logic [PW-1:0] iq_rd, iq_wr, eq_rd, eq_wr;
  logic [CW-1:0] iq_cnt, eq_cnt;

  wire iq_pop = reg_wr && reg_addr == A_IQ1 && iq_cnt != 0;
  wire eq_pop = reg_wr && reg_addr == A_EQ  && eq_cnt != 0;
  wire iq_acc = intq_push && (iq_cnt != FULL || iq_pop);
  wire eq_acc = errq_push && (eq_cnt != FULL || eq_pop);
  wire [18:0] iq_head = iq_mem[iq_rd];
  wire [15:0] eq_head = eq_mem[eq_rd];

  assign clr_v   = (reg_wr && reg_addr == A_DEC) ? reg_wdata : 32'h0;
  assign irq_out = |(decode & mask);

  always_comb begin
    set_v = event_in;
    if (iq_acc) set_v[intq_msi ? 17 : 16] = 1'b1;
    if (eq_acc) set_v[errq_sev == 2'd0 ? 9 : (errq_sev == 2'd1 ? 10 : 11)] = 1'b1;
  end

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr)
      A_DEC: reg_rdata = decode;
      A_MSK: reg_rdata = mask;
      A_EQ:  if (eq_cnt != 0) reg_rdata = {13'h0, 1'b1, 2'b00, eq_head};
      A_IQ1: if (iq_cnt != 0) reg_rdata = {1'b1, iq_head[18], 1'b0, iq_head[17:16], 27'h0};
      A_IQ2: if (iq_cnt != 0) reg_rdata = {16'h0, iq_head[15:0]};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decode   <= '0;
      mask     <= '0;
      iq_rd    <= '0;
      iq_wr    <= '0;
      iq_cnt   <= '0;
      eq_rd    <= '0;
      eq_wr    <= '0;
      eq_cnt   <= '0;
      intq_ovf <= 1'b0;
      errq_ovf <= 1'b0;
    end else begin
      decode <= ((decode & ~clr_v) | set_v) & IMPL;
      if (reg_wr && reg_addr == A_MSK) mask <= reg_wdata & IMPL;
      if (iq_acc) iq_wr <= nxt(iq_wr);
      if (iq_pop) iq_rd <= nxt(iq_rd);
      iq_cnt <= iq_cnt + CW'(iq_acc) - CW'(iq_pop);
      if (eq_acc) eq_wr <= nxt(eq_wr);
      if (eq_pop) eq_rd <= nxt(eq_rd);
      eq_cnt <= eq_cnt + CW'(eq_acc) - CW'(eq_pop);
      if (intq_push && !iq_acc) intq_ovf <= 1'b1;
      if (errq_push && !eq_acc) errq_ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (iq_acc) iq_mem[iq_wr] <= {intq_msi, intq_line, intq_data};
    if (eq_acc) eq_mem[eq_wr] <= errq_reqid;
  end

  // R3
  dec_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DEC && event_in == 0 && !intq_push && !errq_push)
      |=> ((decode & $past(reg_wdata)) == 0));
  // R8
  iq_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_pop && !intq_push) |=> (iq_cnt == $past(iq_cnt) - 1'b1));
  // R9
  iq_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_cnt <= FULL) && (eq_cnt <= FULL));
  // R10
  iq_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intq_push && iq_cnt == FULL && !(reg_wr && reg_addr == A_IQ1))
      |=> (iq_cnt == $past(iq_cnt)) && intq_ovf);
  // R10
  eq_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (errq_push && eq_cnt == FULL && !(reg_wr && reg_addr == A_EQ))
      |=> (eq_cnt == $past(eq_cnt)) && errq_ovf);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intq_ovf |=> intq_ovf) and (errq_ovf |=> errq_ovf));
  // R11
  iq_empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_cnt == 0 && (reg_addr == A_IQ1 || reg_addr == A_IQ2)) |-> (reg_rdata == 0));
endmodule

// File: tb/rp_irq_frontend_tb_top.sv
module rp_irq_frontend_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, event_in = 0;
  logic intq_push = 0, intq_msi = 0, errq_push = 0;
  logic [1:0] intq_line = 0, errq_sev = 0;
  logic [15:0] intq_data = 0, errq_reqid = 0;
  logic irq_out, intq_ovf, errq_ovf;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rp_irq_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in),
    .intq_push(intq_push), .intq_msi(intq_msi), .intq_line(intq_line),
    .intq_data(intq_data), .errq_push(errq_push), .errq_sev(errq_sev),
    .errq_reqid(errq_reqid), .irq_out(irq_out), .intq_ovf(intq_ovf),
    .errq_ovf(errq_ovf));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(input logic [31:0] ev);
    event_in = ev; @(negedge clk); event_in = 0;
  endtask

  task automatic ipush(input logic msi, input logic [1:0] line, input logic [15:0] data);
    intq_push = 1; intq_msi = msi; intq_line = line; intq_data = data;
    @(negedge clk); intq_push = 0;
  endtask

  task automatic epush(input logic [1:0] sev, input logic [15:0] id);
    errq_push = 1; errq_sev = sev; errq_reqid = id;
    @(negedge clk); errq_push = 0;
  endtask

  task automatic t_reset;
    rdchk("R1 decode", 12'h138, 0);
    rdchk("R1 mask", 12'h13C, 0);
    rdchk("R1 intq", 12'h158, 0);
    rdchk("R1 errq", 12'h154, 0);
    chk("R1 flags", {29'h0, irq_out, intq_ovf, errq_ovf}, 0);
  endtask

  task automatic t_decode_mask;
    pulse(32'hFFFF_FFFF);
    rdchk("R2 implemented bits", 12'h138, 32'h1FF3_0FED);
    chk("R4 irq masked", irq_out, 0);
    wr(12'h13C, 32'hFFFF_FFFF);
    rdchk("R4 mask bits", 12'h13C, 32'h1FF3_0FED);
    chk("R4 irq on", irq_out, 1);
    wr(12'h138, 32'h1FF3_0FED);
    rdchk("R3 w1c all", 12'h138, 0);
    chk("R4 irq off", irq_out, 0);
    event_in = 32'h1; reg_addr = 12'h138; reg_wdata = 32'h1; reg_wr = 1;
    @(negedge clk); reg_wr = 0; event_in = 0;
    rdchk("R3 set wins", 12'h138, 32'h1);
    wr(12'h138, 32'h1);
    wr(12'h13C, 32'h4);
    pulse(32'h1);
    chk("R4 unmasked bit only", irq_out, 0);
    pulse(32'h4);
    chk("R4 selected bit", irq_out, 1);
    wr(12'h138, 32'hFFFF_FFFF);
    wr(12'h13C, 0);
    rdchk("R3 cleared", 12'h138, 0);
  endtask

  task automatic t_intq;
    ipush(0, 2, 16'h0);
    ipush(1, 0, 16'hBEEF);
    rdchk("R5 decode 16/17", 12'h138, 32'h0003_0000);
    rdchk("R5 intx word", 12'h158, 32'h9000_0000);
    wr(12'h158, 0);
    rdchk("R8 pop -> msi word", 12'h158, 32'hC000_0000);
    rdchk("R6 msi data", 12'h15C, 32'h0000_BEEF);
    wr(12'h158, 32'h1234);
    rdchk("R11 intq empty w1", 12'h158, 0);
    rdchk("R11 intq empty w2", 12'h15C, 0);
    wr(12'h158, 0);
    rdchk("R8 pop empty no effect", 12'h158, 0);
    wr(12'h138, 32'hFFFF_FFFF);
  endtask

  task automatic t_errq;
    epush(0, 16'h1234);
    epush(1, 16'h5678);
    epush(2, 16'h9ABC);
    rdchk("R7 decode 9..11", 12'h138, 32'h0000_0E00);
    rdchk("R7 head 1", 12'h154, 32'h0004_1234);
    wr(12'h154, 0);
    rdchk("R7 head 2", 12'h154, 32'h0004_5678);
    wr(12'h154, 0);
    rdchk("R7 head 3", 12'h154, 32'h0004_9ABC);
    wr(12'h154, 0);
    rdchk("R11 errq empty", 12'h154, 0);
    wr(12'h154, 0);
    rdchk("R8 errq pop empty", 12'h154, 0);
    chk("R8 no overflow", {30'h0, intq_ovf, errq_ovf}, 0);
    wr(12'h138, 32'hFFFF_FFFF);
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) ipush(0, 2'(i), 16'(i));
    chk("R9 eight fit", intq_ovf, 0);
    wr(12'h138, 32'h0001_0000);
    ipush(0, 3, 16'hFFFF);
    chk("R10 intq overflow", intq_ovf, 1);
    rdchk("R10 dropped leaves decode", 12'h138, 0);
    for (int i = 0; i < 8; i++) begin
      rdchk("R9 intq order", 12'h158, 32'h8000_0000 | (32'(i % 4) << 27));
      wr(12'h158, 0);
    end
    rdchk("R10 intq empty after drain", 12'h158, 0);
    chk("R10 intq ovf sticky", intq_ovf, 1);
    for (int i = 0; i < 8; i++) epush(0, 16'(16'hA0 + i));
    chk("R9 errq eight fit", errq_ovf, 0);
    epush(2, 16'hDEAD);
    chk("R10 errq overflow", errq_ovf, 1);
    for (int i = 0; i < 8; i++) begin
      rdchk("R9 errq order", 12'h154, 32'h0004_0000 | (32'hA0 + 32'(i)));
      wr(12'h154, 0);
    end
    rdchk("R10 errq dropped entry absent", 12'h154, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode_mask();
    t_intq();
    t_errq();
    t_full();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule